// File: doc/BRIEF.md
# 100 Mb/s Transmit Code-Group Framer

This block sits between the MAC-side transmit nibble interface and the line-side path of a 100 Mb/s physical layer. On every rising edge of the transmit clock it samples a 4-bit data nibble together with an enable and an error flag. It returns one registered 5-bit code group per clock for a downstream scrambler or serializer. Between frames it sends idle. At the head of a frame it overwrites the first preamble octet with the start delimiter. Each later nibble goes through the 4B/5B data table. When the enable drops it appends the end delimiter.

A transmit error raised during a frame replaces the code group for that nibble with an illegal code, so the fault reaches the far end. The framer has no configuration, no software access and no flow control. It is a fixed one-cycle encoder with a four-state frame tracker.

Top module: `tx_codegroup_framer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the output is the idle code 11111.
- R2: With no frame in progress and the enable low, the output stays at idle 11111 every cycle.
- R3: The first two nibbles sampled with the enable high after idle are replaced by J (11000) and then K (10001). Their data values are discarded.
- R4: From the third nibble of a frame onwards, each nibble is mapped through the 4B/5B table. For hex 0 to F the codes are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: A nibble sampled with both the enable and the error flag high produces the illegal code 00100. This holds at the J, K and data positions alike.
- R6: When the enable is sampled low after any nibble of a frame, including a frame of only one nibble, the output is T (01101), then R (00111), then idle.
- R7: Each code group appears exactly one clock after the nibble it encodes is sampled.
- R8: A nibble sampled during the cycle in which the framer issues R is discarded. If the enable is still high on the next sample, that nibble starts a new frame with J.
- R9: The error flag has no effect while the enable is low; the output remains idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | High while the MAC presents frame nibbles |
| tx_er | input | 1 | Transmit error flag, meaningful only with tx_en high |
| txd | input | 4 | Transmit data nibble |
| code_grp | output | 5 | Registered 5-bit code group, one per clock |

## Verification
The assertions assume that tx_en, tx_er and txd are known (never X) at every rising edge. They also assume those inputs change only between edges, because the framer samples them combinationally into its next-state and code logic. The stimulus drives every input on the falling clock edge and starts at time zero with defined values. The random frames mostly keep a gap of at least two idle nibbles. One directed case deliberately reopens the enable during the R cycle so that the discard rule is exercised. Error flags are also raised on delimiter positions and while the enable is low.

// File: rtl/cg_pkg.sv
package cg_pkg;
  localparam int NIB_W = 4;
  localparam int CG_W  = 5;

  localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [CG_W-1:0] CG_J    = 5'b11000;
  localparam logic [CG_W-1:0] CG_K    = 5'b10001;
  localparam logic [CG_W-1:0] CG_T    = 5'b01101;
  localparam logic [CG_W-1:0] CG_R    = 5'b00111;
  localparam logic [CG_W-1:0] CG_HALT = 5'b00100;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_SSD2 = 2'd1,
    FS_DATA = 2'd2,
    FS_END  = 2'd3
  } frame_st_e;

  typedef enum logic [2:0] {
    SEL_IDLE = 3'd0,
    SEL_J    = 3'd1,
    SEL_K    = 3'd2,
    SEL_DATA = 3'd3,
    SEL_T    = 3'd4,
    SEL_R    = 3'd5
  } cg_sel_e;

  function automatic logic [CG_W-1:0] enc_4b5b(input logic [NIB_W-1:0] nib);
    logic [CG_W-1:0] c;
    case (nib)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction

  // Data codes: exactly the 16 entries of the table above.
  function automatic logic is_data_code(input logic [CG_W-1:0] c);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < (1 << NIB_W); i++) begin
      if (enc_4b5b(i[NIB_W-1:0]) == c) hit = 1'b1;
    end
    return hit;
  endfunction
endpackage

// File: rtl/cg_nibble_encoder.sv
module cg_nibble_encoder
  import cg_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  output logic [CG_W-1:0]  data_code
);
  always_comb begin
    data_code = enc_4b5b(nib);
  end

  // R4: every encoded nibble is one of the sixteen data codes, never a control code
  always_comb begin
    if (!$isunknown(nib)) begin
      assert_data_code_legal_R4: assert (is_data_code(data_code) &&
                                         data_code != CG_IDLE && data_code != CG_J &&
                                         data_code != CG_K && data_code != CG_T &&
                                         data_code != CG_R && data_code != CG_HALT);
    end
  end
endmodule

// File: rtl/cg_frame_ctrl.sv
module cg_frame_ctrl
  import cg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tx_en,
  output cg_sel_e   sel,
  output logic      at_idle,
  output logic      at_end
);
  frame_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    sel  = SEL_IDLE;
    case (st_q)
      FS_IDLE: begin
        sel  = tx_en ? SEL_J : SEL_IDLE;
        st_d = tx_en ? FS_SSD2 : FS_IDLE;
      end
      FS_SSD2: begin
        sel  = tx_en ? SEL_K : SEL_T;
        st_d = tx_en ? FS_DATA : FS_END;
      end
      FS_DATA: begin
        sel  = tx_en ? SEL_DATA : SEL_T;
        st_d = tx_en ? FS_DATA : FS_END;
      end
      default: begin
        sel  = SEL_R;
        st_d = FS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FS_IDLE;
    else        st_q <= st_d;
  end

  assign at_idle = (st_q == FS_IDLE);
  assign at_end  = (st_q == FS_END);

  // R8: the R slot lasts one cycle and always returns to idle
  assert_end_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |=> at_idle);

  // R6: leaving a frame always passes through the end slot
  assert_frame_exit_via_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_idle && !at_end && !tx_en) |=> at_end);
endmodule

// File: rtl/tx_codegroup_framer.sv
module tx_codegroup_framer
  import cg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       tx_er,
  input  logic [3:0] txd,
  output logic [4:0] code_grp
);
  cg_sel_e          sel;
  logic             ctrl_idle;
  logic             ctrl_end;
  logic [CG_W-1:0]  data_code;
  logic [CG_W-1:0]  code_d;
  logic [CG_W-1:0]  code_q;
  logic             err_hit;

  cg_frame_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .sel     (sel),
    .at_idle (ctrl_idle),
    .at_end  (ctrl_end)
  );

  cg_nibble_encoder u_enc (
    .nib       (txd),
    .data_code (data_code)
  );

  // Error substitution applies to every nibble position the MAC owns.
  assign err_hit = tx_en && tx_er && (sel == SEL_J || sel == SEL_K || sel == SEL_DATA);

  always_comb begin
    case (sel)
      SEL_J:    code_d = CG_J;
      SEL_K:    code_d = CG_K;
      SEL_DATA: code_d = data_code;
      SEL_T:    code_d = CG_T;
      SEL_R:    code_d = CG_R;
      default:  code_d = CG_IDLE;
    endcase
    if (err_hit) code_d = CG_HALT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= CG_IDLE;
    else        code_q <= code_d;
  end

  assign code_grp = code_q;

  // R3: J is followed by K, or by T or the error code when the frame is cut short
  assert_j_then_k_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == CG_J) |=> (code_q == CG_K || code_q == CG_T || code_q == CG_HALT));

  // R6: T is always followed by R
  assert_t_then_r_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == CG_T) |=> (code_q == CG_R));

  // R8: after R comes idle or a fresh start of frame
  assert_r_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == CG_R) |=> (code_q == CG_IDLE || code_q == CG_J || code_q == CG_HALT));

  // R5: an errored nibble inside a frame yields the illegal code one cycle later
  assert_err_to_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_er && !ctrl_end) |=> (code_q == CG_HALT));

  // R2, R9: quiet line stays idle whatever the error flag does
  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && ctrl_idle) |=> (code_q == CG_IDLE));
endmodule

// File: tb/tb_tx_codegroup_framer.sv
`timescale 1ns/1ps
module tb_tx_codegroup_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic [4:0] code_grp;

  int n_chk = 0;
  int n_bad = 0;
  int phase = 0;   // 0 quiet, 1 J sent, 2 in data, 3 T sent

  always #4 clk = ~clk;

  tx_codegroup_framer dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er),
    .txd(txd), .code_grp(code_grp)
  );

  localparam logic [4:0] DTAB [16] = '{5'h1E, 5'h09, 5'h14, 5'h15, 5'h0A, 5'h0B,
                                       5'h0E, 5'h0F, 5'h12, 5'h13, 5'h16, 5'h17,
                                       5'h1A, 5'h1B, 5'h1C, 5'h1D};

  function automatic logic [4:0] ref_code(input int ph, input logic en,
                                          input logic er, input logic [3:0] d);
    if (ph == 3) return 5'b00111;
    if (!en) return (ph == 0) ? 5'b11111 : 5'b01101;
    if (er) return 5'b00100;
    if (ph == 0) return 5'b11000;
    if (ph == 1) return 5'b10001;
    return DTAB[d];
  endfunction

  function automatic int ref_next(input int ph, input logic en);
    if (ph == 3) return 0;
    if (ph == 0) return en ? 1 : 0;
    return en ? 2 : 3;
  endfunction

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: code_grp=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  // Drive on falling edge, check one full cycle later (R7 latency).
  task automatic step(input logic en, input logic er, input logic [3:0] d, input string req);
    logic [4:0] e;
    tx_en = en; tx_er = er; txd = d;
    e = ref_code(phase, en, er, d);
    phase = ref_next(phase, en);
    @(posedge clk);
    @(negedge clk);
    check(req, code_grp, e);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 in reset", code_grp, 5'b11111);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", code_grp, 5'b11111);

    // R2 quiet line, R9 error flag alone
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 4'(i), "R2 idle");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 4'(i * 3), "R9 err ignored");

    // R3 R4 R7 full table in one frame
    step(1'b1, 1'b0, 4'h5, "R3 J");
    step(1'b1, 1'b0, 4'h5, "R3 K");
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 4'(i), "R4 table");
    step(1'b0, 1'b0, 4'h0, "R6 T");
    step(1'b0, 1'b0, 4'h0, "R6 R");
    step(1'b0, 1'b0, 4'h0, "R6 idle");

    // R6 one-nibble frame
    step(1'b1, 1'b0, 4'hA, "R3 J short");
    step(1'b0, 1'b0, 4'h0, "R6 T short");
    step(1'b0, 1'b0, 4'h0, "R6 R short");
    step(1'b0, 1'b0, 4'h0, "R6 idle short");

    // R5 errors on J, K and data positions
    step(1'b1, 1'b1, 4'h1, "R5 halt on J");
    step(1'b1, 1'b1, 4'h2, "R5 halt on K");
    step(1'b1, 1'b0, 4'h7, "R4 data");
    step(1'b1, 1'b1, 4'h7, "R5 halt on data");
    step(1'b1, 1'b0, 4'h7, "R4 data after err");
    step(1'b0, 1'b1, 4'h0, "R6 T with er");
    // R8 enable reopened during R slot
    step(1'b1, 1'b1, 4'h3, "R8 R slot ignores nibble");
    step(1'b1, 1'b0, 4'h3, "R8 restart J");
    step(1'b1, 1'b0, 4'h3, "R3 K after restart");
    step(1'b1, 1'b0, 4'hC, "R4 data after restart");
    step(1'b0, 1'b0, 4'h0, "R6 T");
    step(1'b0, 1'b0, 4'h0, "R6 R");

    // Random frames
    for (int f = 0; f < 300; f++) begin
      int len;
      int gap;
      len = 1 + int'($urandom_range(24));
      gap = 2 + int'($urandom_range(4));
      for (int k = 0; k < len; k++) begin
        step(1'b1, ($urandom_range(15) == 0), 4'($urandom_range(15)), "R4 random frame");
      end
      for (int k = 0; k < gap; k++) begin
        step(1'b0, ($urandom_range(3) == 0), 4'($urandom_range(15)), "R6 random gap");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule